// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Slice

This block is one slice of a programmable AND-OR fabric. Thirty-six routed signals enter. Each is used in its plain and its inverted form, which gives a 72-literal field. A configuration store holds one literal-enable mask for each of 87 product terms. The first 80 terms are general terms. They are split into four banks of 20, one bank for each group of four macrocells. Each macrocell ORs any subset of its own bank, limited to sixteen terms. Several macrocells of the same group may pick the same term, which shares it. The last seven terms are control terms: four output enables, a set, a reset and a clock. Each control term has its own invert bit.

Configuration arrives as addressed 72-bit words through a word-write port. A small controller has three states: `CFG_IDLE`, `CFG_COMMIT` and `CFG_DROP`. From any state, a sampled write moves it to `CFG_COMMIT` when the word is legal and to `CFG_DROP` when it is not. With no write, it returns to `CFG_IDLE`. A word is stored only on the edge that leaves `CFG_COMMIT`. The address map is:

- 0..86: literal-enable mask of term t.
- 87..102: steering mask of macrocell m, at address 87+m.
- 103: the control word.

Every output is combinational from the inputs and the stored configuration.

Top module: `ptl_block`

## Requirements
- R1: Bit 2i of a term mask enables the plain form of input i, and bit 2i+1 enables its inverted form. A term is the AND of its enabled literals.
- R2: A term whose mask has no bits set evaluates to 1.
- R3: Macrocell m belongs to group g = m/4. Bit k (k < 20) of its steering word selects general term 20g+k. Its sum output is the OR of the selected terms.
- R4: A macrocell whose steering mask is zero drives its sum output to 0, whatever the term values.
- R5: A steering word with more than 16 of its low 20 bits set is discarded, and the previous mask stays in force. A word with exactly 16 bits set is stored.
- R6: A term may feed several macrocells of its own group. Steering-word bits 20 and above are ignored, so a macrocell cannot reach a term of another group.
- R7: Macrocells 0..7 take their enable from term 80 (select bit 0) or term 81 (select bit 1). Macrocells 8..15 take it from term 82 or term 83. The select bit of macrocell m is bit 7+m of the control word.
- R8: The set, reset and clock outputs are driven by terms 84, 85 and 86 respectively.
- R9: Control-word bits 0..6 invert terms 80..86 in that order, which turns the AND of literals into an OR of their complements.
- R10: A write sampled at clock edge k changes the outputs only after edge k+1. Outputs keep their values until then.
- R11: A write to an address above 103 has no effect on any output.
- R12: After reset, all masks and control bits are zero. So every sum is 0, every enable is 1, and set, reset and clock are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_sig | input | 36 | Routed input signals |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 7 | Configuration word address |
| wr_data | input | 72 | Configuration word |
| mc_sum | output | 16 | Macrocell sum outputs |
| mc_oe | output | 16 | Output enable selected for each macrocell |
| blk_set | output | 1 | Set control term |
| blk_reset | output | 1 | Reset control term |
| blk_pt_clk | output | 1 | Product-term clock |

## Verification
The stability property assumes that the routed inputs are held steady between the edges where they are sampled. It also assumes that configuration changes only through the write port. The bench therefore drives inputs and writes only on the falling edge, and keeps each vector in place for a full cycle.

The steering-limit check assumes that only legal words ever reach the store. Oversized steering words are therefore supplied on purpose, so the check sees the filter working rather than an absence of such words. Random configurations keep the steering masks sparse and the term masks to a few literals, so that the sums toggle instead of sticking at 0.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
    localparam int unsigned DEF_N_IN   = 36;
    localparam int unsigned DEF_N_MC   = 16;
    localparam int unsigned DEF_GRP_SZ = 4;
    localparam int unsigned DEF_GEN_PT = 80;
    localparam int unsigned DEF_MAX_PT = 16;
    localparam int unsigned N_CTL      = 7;   // oe0..oe3, set, reset, clock

    typedef enum logic [1:0] {
        CFG_IDLE   = 2'd0,
        CFG_COMMIT = 2'd1,
        CFG_DROP   = 2'd2
    } cfg_state_e;
endpackage

// File: rtl/ptl_cfg_store.sv
module ptl_cfg_store
    import ptl_pkg::*;
#(
    parameter int unsigned N_IN   = DEF_N_IN,
    parameter int unsigned N_MC   = DEF_N_MC,
    parameter int unsigned GRP_SZ = DEF_GRP_SZ,
    parameter int unsigned GEN_PT = DEF_GEN_PT,
    parameter int unsigned MAX_PT = DEF_MAX_PT,
    localparam int unsigned LITS   = 2 * N_IN,
    localparam int unsigned N_PT   = GEN_PT + N_CTL,
    localparam int unsigned GRP_PT = GEN_PT / (N_MC / GRP_SZ),
    localparam int unsigned A_CTL  = N_PT + N_MC,
    localparam int unsigned AW     = $clog2(A_CTL + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [LITS-1:0]               wr_data,
    output logic [N_PT-1:0][LITS-1:0]     term_mask,
    output logic [N_MC-1:0][GRP_PT-1:0]   steer,
    output logic [N_CTL-1:0]              ctl_pol,
    output logic [N_MC-1:0]               oe_sel,
    output cfg_state_e                    cfg_state
);
    localparam logic [AW-1:0] A_STEER_V = AW'(N_PT);
    localparam logic [AW-1:0] A_CTL_V   = AW'(A_CTL);

    cfg_state_e             nxt_state;
    logic                   wr_ok;
    logic [AW-1:0]          stg_addr;
    logic [LITS-1:0]        stg_data;

    // legality of the word on the port this cycle
    always_comb begin
        if (wr_addr < A_STEER_V)
            wr_ok = 1'b1;
        else if (wr_addr < A_CTL_V)
            wr_ok = ($countones(wr_data[GRP_PT-1:0]) <= MAX_PT);
        else
            wr_ok = (wr_addr == A_CTL_V);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_state <= CFG_IDLE;
        else        cfg_state <= nxt_state;
    end

    // transitions
    always_comb begin
        nxt_state = CFG_IDLE;
        unique case (cfg_state)
            CFG_IDLE, CFG_COMMIT, CFG_DROP: begin
                if (wr_en) nxt_state = wr_ok ? CFG_COMMIT : CFG_DROP;
                else       nxt_state = CFG_IDLE;
            end
            default: nxt_state = CFG_IDLE;
        endcase
    end

    // staging register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_addr <= '0;
            stg_data <= '0;
        end else if (wr_en) begin
            stg_addr <= wr_addr;
            stg_data <= wr_data;
        end
    end

    // outputs: configuration committed when leaving CFG_COMMIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_mask <= '0;
            steer     <= '0;
            ctl_pol   <= '0;
            oe_sel    <= '0;
        end else if (cfg_state == CFG_COMMIT) begin
            for (int t = 0; t < int'(N_PT); t++)
                if (stg_addr == AW'(t)) term_mask[t] <= stg_data;
            for (int m = 0; m < int'(N_MC); m++)
                if (stg_addr == A_STEER_V + AW'(m)) steer[m] <= stg_data[GRP_PT-1:0];
            if (stg_addr == A_CTL_V) begin
                ctl_pol <= stg_data[N_CTL-1:0];
                oe_sel  <= stg_data[N_CTL +: N_MC];
            end
        end
    end
endmodule

// File: rtl/ptl_and_plane.sv
module ptl_and_plane #(
    parameter int unsigned N_IN = 36,
    parameter int unsigned N_PT = 87,
    localparam int unsigned LITS = 2 * N_IN
) (
    input  logic [N_IN-1:0]             in_sig,
    input  logic [N_PT-1:0][LITS-1:0]   term_mask,
    output logic [N_PT-1:0]             pt
);
    logic [LITS-1:0] lits;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]   = in_sig[i];
        assign lits[2*i+1] = ~in_sig[i];
    end

    // disabled literals read as 1, so an empty mask yields 1
    for (genvar t = 0; t < N_PT; t++) begin : g_term
        assign pt[t] = &(lits | ~term_mask[t]);
    end
endmodule

// File: rtl/ptl_or_plane.sv
module ptl_or_plane #(
    parameter int unsigned N_MC   = 16,
    parameter int unsigned GRP_SZ = 4,
    parameter int unsigned GEN_PT = 80,
    localparam int unsigned N_GRPS = N_MC / GRP_SZ,
    localparam int unsigned GRP_PT = GEN_PT / N_GRPS
) (
    input  logic [GEN_PT-1:0]             pt_gen,
    input  logic [N_MC-1:0][GRP_PT-1:0]   steer,
    output logic [N_MC-1:0]               mc_sum
);
    for (genvar g = 0; g < N_GRPS; g++) begin : g_grp
        for (genvar k = 0; k < GRP_SZ; k++) begin : g_mc
            assign mc_sum[g*GRP_SZ+k] = |(steer[g*GRP_SZ+k] & pt_gen[g*GRP_PT +: GRP_PT]);
        end
    end
endmodule

// File: rtl/ptl_ctl_terms.sv
module ptl_ctl_terms
    import ptl_pkg::*;
#(
    parameter int unsigned N_MC = 16
) (
    input  logic [N_CTL-1:0]  pt_ctl,
    input  logic [N_CTL-1:0]  ctl_pol,
    input  logic [N_MC-1:0]   oe_sel,
    output logic [N_MC-1:0]   mc_oe,
    output logic              blk_set,
    output logic              blk_reset,
    output logic              blk_pt_clk
);
    logic [N_CTL-1:0] ctl;

    assign ctl        = pt_ctl ^ ctl_pol;
    assign blk_set    = ctl[4];
    assign blk_reset  = ctl[5];
    assign blk_pt_clk = ctl[6];

    for (genvar m = 0; m < N_MC; m++) begin : g_oe
        if (m < N_MC / 2) begin : g_upper
            assign mc_oe[m] = oe_sel[m] ? ctl[1] : ctl[0];
        end else begin : g_lower
            assign mc_oe[m] = oe_sel[m] ? ctl[3] : ctl[2];
        end
    end
endmodule

// File: rtl/ptl_block.sv
module ptl_block
    import ptl_pkg::*;
#(
    parameter int unsigned N_IN   = DEF_N_IN,
    parameter int unsigned N_MC   = DEF_N_MC,
    parameter int unsigned GRP_SZ = DEF_GRP_SZ,
    parameter int unsigned GEN_PT = DEF_GEN_PT,
    parameter int unsigned MAX_PT = DEF_MAX_PT,
    localparam int unsigned LITS   = 2 * N_IN,
    localparam int unsigned N_PT   = GEN_PT + N_CTL,
    localparam int unsigned GRP_PT = GEN_PT / (N_MC / GRP_SZ),
    localparam int unsigned AW     = $clog2(N_PT + N_MC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_sig,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LITS-1:0]   wr_data,
    output logic [N_MC-1:0]   mc_sum,
    output logic [N_MC-1:0]   mc_oe,
    output logic              blk_set,
    output logic              blk_reset,
    output logic              blk_pt_clk
);
    logic [N_PT-1:0][LITS-1:0]    term_mask;
    logic [N_MC-1:0][GRP_PT-1:0]  steer;
    logic [N_CTL-1:0]             ctl_pol;
    logic [N_MC-1:0]              oe_sel;
    logic [N_PT-1:0]              pt;
    cfg_state_e                   cfg_state;

    ptl_cfg_store #(
        .N_IN(N_IN), .N_MC(N_MC), .GRP_SZ(GRP_SZ), .GEN_PT(GEN_PT), .MAX_PT(MAX_PT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .term_mask(term_mask), .steer(steer), .ctl_pol(ctl_pol), .oe_sel(oe_sel),
        .cfg_state(cfg_state)
    );

    ptl_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .in_sig(in_sig), .term_mask(term_mask), .pt(pt)
    );

    ptl_or_plane #(.N_MC(N_MC), .GRP_SZ(GRP_SZ), .GEN_PT(GEN_PT)) u_or (
        .pt_gen(pt[GEN_PT-1:0]), .steer(steer), .mc_sum(mc_sum)
    );

    ptl_ctl_terms #(.N_MC(N_MC)) u_ctl (
        .pt_ctl(pt[N_PT-1:GEN_PT]), .ctl_pol(ctl_pol), .oe_sel(oe_sel),
        .mc_oe(mc_oe), .blk_set(blk_set), .blk_reset(blk_reset), .blk_pt_clk(blk_pt_clk)
    );
endmodule

// File: rtl/ptl_block_chk.sv
module ptl_block_chk
    import ptl_pkg::*;
#(
    parameter int unsigned N_IN   = DEF_N_IN,
    parameter int unsigned N_MC   = DEF_N_MC,
    parameter int unsigned GEN_PT = DEF_GEN_PT,
    parameter int unsigned GRP_PT = 20,
    parameter int unsigned MAX_PT = DEF_MAX_PT,
    localparam int unsigned LITS  = 2 * N_IN,
    localparam int unsigned N_PT  = GEN_PT + N_CTL
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_IN-1:0]               in_sig,
    input  logic                          wr_en,
    input  logic [N_MC-1:0]               mc_sum,
    input  logic [N_MC-1:0]               mc_oe,
    input  cfg_state_e                    cfg_state,
    input  logic [N_MC-1:0][GRP_PT-1:0]   steer,
    input  logic [N_PT-1:0][LITS-1:0]     term_mask,
    input  logic [N_PT-1:0]               pt,
    input  logic [N_CTL-1:0]              ctl_pol
);
    // R10: a write always moves the controller out of idle
    p_write_leaves_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_state != CFG_IDLE);

    // R10: without a write the controller returns to idle
    p_no_write_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> cfg_state == CFG_IDLE);

    // R10: outputs hold when no commit happened and inputs held
    p_hold_without_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_state) != CFG_COMMIT && $stable(in_sig)) |-> ($stable(mc_sum) && $stable(mc_oe)));

    always @(posedge clk) begin
        if (rst_n) begin
            for (int m = 0; m < int'(N_MC); m++) begin
                p_steer_cap_r5: assert ($countones(steer[m]) <= MAX_PT);
                p_empty_sum_r4: assert (steer[m] != '0 || mc_sum[m] == 1'b0);
                if (m < int'(N_MC) / 2) begin
                    p_oe_upper_pair_r7: assert (mc_oe[m] == (pt[GEN_PT] ^ ctl_pol[0])
                                             || mc_oe[m] == (pt[GEN_PT+1] ^ ctl_pol[1]));
                end else begin
                    p_oe_lower_pair_r7: assert (mc_oe[m] == (pt[GEN_PT+2] ^ ctl_pol[2])
                                             || mc_oe[m] == (pt[GEN_PT+3] ^ ctl_pol[3]));
                end
            end
            for (int t = 0; t < int'(N_PT); t++) begin
                p_empty_term_r2: assert (term_mask[t] != '0 || pt[t] == 1'b1);
            end
        end
    end
endmodule

bind ptl_block ptl_block_chk #(
    .N_IN(N_IN), .N_MC(N_MC), .GEN_PT(GEN_PT), .GRP_PT(GRP_PT), .MAX_PT(MAX_PT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_sig(in_sig), .wr_en(wr_en),
    .mc_sum(mc_sum), .mc_oe(mc_oe), .cfg_state(cfg_state), .steer(steer),
    .term_mask(term_mask), .pt(pt), .ctl_pol(ctl_pol)
);

// File: tb/ptl_block_bench.sv
`timescale 1ns/1ps
module ptl_block_bench;
    localparam int NI = 36, NM = 16, NP = 87, GP = 20, LW = 72;
    localparam int A_ST = 87, A_CT = 103;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NI-1:0]  in_sig = '0;
    logic           wr_en = 1'b0;
    logic [6:0]     wr_addr = '0;
    logic [LW-1:0]  wr_data = '0;
    logic [NM-1:0]  mc_sum, mc_oe;
    logic           blk_set, blk_reset, blk_pt_clk;

    ptl_block u_ptl_block (
        .clk(clk), .rst_n(rst_n), .in_sig(in_sig), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mc_sum(mc_sum), .mc_oe(mc_oe), .blk_set(blk_set),
        .blk_reset(blk_reset), .blk_pt_clk(blk_pt_clk)
    );

    always #4 clk = ~clk;

    // reference configuration
    logic [LW-1:0] m_mask [NP];
    logic [GP-1:0] m_steer [NM];
    logic [6:0]    m_pol;
    logic [NM-1:0] m_sel;

    logic [34:0] q_exp [$];
    string       q_tag [$];
    int vectors = 0, miscompares = 0;
    bit done = 0;

    function automatic logic [34:0] ref_eval(input logic [NI-1:0] x);
        logic [NP-1:0] p;
        logic [NM-1:0] s, o;
        logic [6:0] c;
        for (int t = 0; t < NP; t++) begin
            p[t] = 1'b1;
            for (int j = 0; j < LW; j++)
                if (m_mask[t][j]) p[t] = p[t] & ((j % 2 == 1) ? ~x[j/2] : x[j/2]);
        end
        for (int i = 0; i < 7; i++) c[i] = p[80+i] ^ m_pol[i];
        for (int m = 0; m < NM; m++) begin
            s[m] = 1'b0;
            for (int k = 0; k < GP; k++)
                if (m_steer[m][k]) s[m] = s[m] | p[(m/4)*GP + k];
            o[m] = (m < 8) ? c[m_sel[m]] : c[2 + int'(m_sel[m])];
        end
        return {s, o, c[6:4]};
    endfunction

    task automatic push_exp(input string tag);
        q_exp.push_back(ref_eval(in_sig));
        q_tag.push_back(tag);
    endtask

    task automatic apply(input logic [NI-1:0] x, input string tag);
        @(negedge clk);
        in_sig = x;
        push_exp(tag);
    endtask

    task automatic model_write(input int a, input logic [LW-1:0] d);
        if (a < A_ST) m_mask[a] = d;
        else if (a < A_CT) begin
            if ($countones(d[GP-1:0]) <= 16) m_steer[a-A_ST] = d[GP-1:0];
        end else if (a == A_CT) begin
            m_pol = d[6:0];
            m_sel = d[22:7];
        end
    endtask

    // write; when chk is set, checks old outputs before commit (R10)
    task automatic cfg_write(input int a, input logic [LW-1:0] d, input bit chk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (chk) push_exp("R10 before commit");
        model_write(a, d);
        @(negedge clk);
        if (chk) push_exp("R10 after commit");
    endtask

    function automatic logic [LW-1:0] sparse_mask();
        logic [LW-1:0] r = '0;
        int n = $urandom_range(0, 3);
        for (int i = 0; i < n; i++) r[$urandom_range(0, LW-1)] = 1'b1;
        return r;
    endfunction

    // monitor: compare away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_exp.size() > 0) begin
                logic [34:0] e;
                logic [34:0] a;
                string tg;
                e = q_exp.pop_front();
                tg = q_tag.pop_front();
                a = {mc_sum, mc_oe, blk_pt_clk, blk_reset, blk_set};
                vectors++;
                if (a !== e) begin
                    miscompares++;
                    $display("FAIL %s: actual %h expected %h", tg, a, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++; miscompares++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NP; t++) m_mask[t] = '0;
        for (int m = 0; m < NM; m++) m_steer[m] = '0;
        m_pol = '0; m_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        apply(36'h5A5A5A5A5, "R12 reset state");
        apply(36'h0, "R12 reset state");

        // R2 / R3: empty term 0 steered to macrocell 0
        cfg_write(A_ST + 0, 72'h1, 1'b1);
        apply(36'hFFFFFFFFF, "R2 empty term is one");

        // R1: term 1 uses plain input 5, then inverted input 5
        cfg_write(1, 72'(1) << 10, 1'b0);
        cfg_write(A_ST + 1, 72'h2, 1'b0);
        apply(36'h0, "R1 plain literal low");
        apply(36'h20, "R1 plain literal high");
        cfg_write(1, 72'(1) << 11, 1'b0);
        apply(36'h0, "R1 inverted literal");
        apply(36'h20, "R1 inverted literal");

        // R4: macrocell 2 steered to nothing
        apply(36'hABCDEF012, "R4 zero steered sum");

        // R5: 17-bit word dropped, 16-bit word stored (macrocell 3)
        cfg_write(A_ST + 3, 72'h1FFFF, 1'b0);
        apply(36'h0, "R5 oversize steering dropped");
        cfg_write(A_ST + 3, 72'h0FFFF, 1'b0);
        apply(36'h0, "R5 sixteen terms accepted");

        // R6: upper steering bits ignored; group-local term 20
        cfg_write(A_ST + 5, 72'(1) << 40, 1'b0);
        cfg_write(20, 72'(1) << 0, 1'b0);
        cfg_write(A_ST + 4, 72'h1, 1'b0);
        apply(36'h0, "R6 upper steering bits ignored");
        apply(36'h1, "R6 group term selected");
        cfg_write(A_ST + 6, 72'h1, 1'b0);
        apply(36'h1, "R6 shared term in group");

        // R7 / R8 / R9: control terms
        cfg_write(80, 72'(1) << 0, 1'b0);
        cfg_write(81, 72'(1) << 3, 1'b0);
        cfg_write(82, 72'(1) << 4, 1'b0);
        cfg_write(83, 72'(1) << 7, 1'b0);
        cfg_write(84, 72'(1) << 8, 1'b0);
        cfg_write(85, 72'(1) << 11, 1'b0);
        cfg_write(86, 72'(1) << 12, 1'b0);
        apply(36'h0, "R8 control terms");
        apply(36'h7F, "R8 control terms");
        cfg_write(A_CT, {49'h0, 16'hF0F0, 7'h00}, 1'b0);
        apply(36'h2, "R7 enable select");
        apply(36'h9, "R7 enable select");
        cfg_write(A_CT, {49'h0, 16'h3C3C, 7'h55}, 1'b1);
        apply(36'h5, "R9 polarity invert");
        apply(36'h3A, "R9 polarity invert");

        // R11: out-of-map address
        cfg_write(110, {72{1'b1}}, 1'b0);
        apply(36'h3A, "R11 out-of-map write ignored");

        // R3: random configurations
        for (int r = 0; r < 20; r++) begin
            for (int t = 0; t < NP; t++) cfg_write(t, sparse_mask(), 1'b0);
            for (int m = 0; m < NM; m++)
                cfg_write(A_ST + m, 72'($urandom & $urandom & 32'hFFFFF), 1'b0);
            cfg_write(A_CT, 72'({$urandom, $urandom}), r == 0);
            for (int v = 0; v < 20; v++)
                apply({4'($urandom), 32'($urandom)}, "R3 random sum of products");
        end

        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule